// File: doc/BRIEF.md
# Partitioned Shader Register File

This block is the operand store of a vertex-processing core. It has four banks of 128-bit entries, each entry holding four 32-bit components. The input bank has 16 entries: the host fills it and programs only read it. The output bank has 16 entries: programs only write it and the host drains it. The temporary bank has 32 entries, is read and written by programs, and is split into fixed windows of 10 entries for up to three threads. The constant bank has 256 entries: the host loads it and programs only read it.

Each cycle, up to three source operands are read combinationally, and one program result may be written. The `thread` input selects the temporary window for the whole instruction. A source or destination that the bank's direction forbids, or that falls outside the bank or window, raises a per-cycle error flag. A rejected write changes nothing, and a rejected read returns zero. A read of a location that is being written in the same cycle returns the new data.

Top module: `shader_regfile`

## Requirements
- R1: After reset, every entry of the input, output and temporary banks reads as zero.
- R2: Bank code 0 is the input bank. A host write (`in_wr_en`) is visible to program reads on the next cycle. A program write with `wr_bank`=0 asserts `wr_err` in that cycle and leaves the bank unchanged.
- R3: Bank code 1 is the output bank. A legal program write is visible on `out_rd_data` on the next cycle. A valid source with bank code 1 asserts its `src_err` bit and returns zero data.
- R4: Bank code 2 is the temporary bank. Thread t (0 to 2) with index i (0 to 9) maps to physical entry t*10+i, so the three threads cannot see each other's data.
- R5: A temporary access with an index of 10 or more, or with `thread`=3, is an error. The write is suppressed and `wr_err` is asserted. A valid read asserts `src_err` and returns zero.
- R6: Bank code 3 is the constant bank. It is loaded only through the host constant port and is read by programs at indices 0 to 255. A program write with `wr_bank`=3 asserts `wr_err` and has no effect.
- R7: Write-first bypass. In the cycle a location is written, a read of that location returns the written data. This holds for host fills of the input bank, host loads of the constant bank, program writes to the temporary bank and program writes to the output bank (seen on `out_rd_data`).
- R8: The three source ports work independently in the same cycle, each with its own bank, index, data and error bit. `src_err` bits are asserted only for valid sources.
- R9: An index of 16 or more on the input or output bank is an error: a program write is suppressed with `wr_err`, and a valid read asserts `src_err` and returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thread | input | 2 | Thread owning the current instruction |
| src_valid | input | 3 | Per-source operand request |
| src_bank | input | 3x2 | Per-source bank code |
| src_idx | input | 3x8 | Per-source entry index |
| src_data | output | 3x128 | Per-source operand data |
| src_err | output | 3 | Per-source illegal-read flag |
| wr_en | input | 1 | Program result write |
| wr_bank | input | 2 | Destination bank code |
| wr_idx | input | 8 | Destination index |
| wr_data | input | 128 | Result data |
| wr_err | output | 1 | Illegal-write flag |
| in_wr_en | input | 1 | Host input-bank fill |
| in_wr_idx | input | 4 | Fill index |
| in_wr_data | input | 128 | Fill data |
| const_wr_en | input | 1 | Host constant load |
| const_wr_idx | input | 8 | Constant index |
| const_wr_data | input | 128 | Constant data |
| out_rd_idx | input | 4 | Host drain index |
| out_rd_data | output | 128 | Drained output entry |

## Verification
The hardest situation to reach from the ports is the one where window translation and bypass interact. Examples are a write and a read by the same thread to one temporary index in the same cycle, and a write from an out-of-window index such as thread 0, index 10. That second write would land in thread 1's entry 0 if it were not suppressed. Directed steps build both cases on purpose. Thread 1's entry 0 is loaded first, then the rejected write is issued, then the entry is read back. After that, a random phase uses small indices (0 to 19) and all four thread codes, so that bypass hits, window edges and out-of-range errors occur often. A behavioural model compares every output on every cycle.

// File: rtl/shader_regfile.sv
`timescale 1ns/1ps
module shader_regfile #(
  parameter int W      = 128,
  parameter int NSRC   = 3,
  parameter int NIO    = 16,
  parameter int NTEMP  = 32,
  parameter int NTHR   = 3,
  parameter int WIN    = 10,
  parameter int NCONST = 256
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [1:0]                            thread,
  input  logic [NSRC-1:0]                       src_valid,
  input  logic [NSRC-1:0][1:0]                  src_bank,
  input  logic [NSRC-1:0][$clog2(NCONST)-1:0]   src_idx,
  output logic [NSRC-1:0][W-1:0]                src_data,
  output logic [NSRC-1:0]                       src_err,
  input  logic                                  wr_en,
  input  logic [1:0]                            wr_bank,
  input  logic [$clog2(NCONST)-1:0]             wr_idx,
  input  logic [W-1:0]                          wr_data,
  output logic                                  wr_err,
  input  logic                                  in_wr_en,
  input  logic [$clog2(NIO)-1:0]                in_wr_idx,
  input  logic [W-1:0]                          in_wr_data,
  input  logic                                  const_wr_en,
  input  logic [$clog2(NCONST)-1:0]             const_wr_idx,
  input  logic [W-1:0]                          const_wr_data,
  input  logic [$clog2(NIO)-1:0]                out_rd_idx,
  output logic [W-1:0]                          out_rd_data
);
  localparam int IXW = $clog2(NCONST);
  localparam int IOW = $clog2(NIO);
  localparam int TW  = $clog2(NTEMP);
  localparam logic [1:0] B_IN = 2'd0, B_OUT = 2'd1, B_TMP = 2'd2;

  logic [W-1:0] in_mem  [NIO];
  logic [W-1:0] out_mem [NIO];
  logic [W-1:0] tmp_mem [NTEMP];
  logic [W-1:0] cst_mem [NCONST];

  wire          thr_ok = 32'(thread) < NTHR;
  wire [TW-1:0] base   = TW'(32'(thread) * WIN);

  wire          wr_tmp_ok = wr_bank == B_TMP && thr_ok && 32'(wr_idx) < WIN;
  wire          wr_out_ok = wr_bank == B_OUT && 32'(wr_idx) < NIO;
  wire [TW-1:0] wr_phys   = base + TW'(wr_idx);
  wire          tmp_we    = wr_en && wr_tmp_ok;
  wire          out_we    = wr_en && wr_out_ok;
  assign wr_err = wr_en && !wr_tmp_ok && !wr_out_ok;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic          ok;
    logic [W-1:0]  val;
    wire  [IOW-1:0] io_a = src_idx[g][IOW-1:0];
    wire  [TW-1:0]  t_a  = base + TW'(src_idx[g]);
    always_comb begin
      ok  = 1'b0;
      val = '0;
      case (src_bank[g])
        B_IN: begin
          ok  = 32'(src_idx[g]) < NIO;
          val = (in_wr_en && in_wr_idx == io_a) ? in_wr_data : in_mem[io_a];
        end
        B_OUT: ok = 1'b0;
        B_TMP: begin
          ok  = thr_ok && 32'(src_idx[g]) < WIN;
          val = (tmp_we && wr_phys == t_a) ? wr_data : tmp_mem[t_a];
        end
        default: begin
          ok  = 1'b1;
          val = (const_wr_en && const_wr_idx == src_idx[g]) ? const_wr_data : cst_mem[src_idx[g]];
        end
      endcase
    end
    assign src_err[g]  = src_valid[g] && !ok;
    assign src_data[g] = ok ? val : '0;
  end

  assign out_rd_data = (out_we && wr_idx[IOW-1:0] == out_rd_idx) ? wr_data : out_mem[out_rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NIO; i++) begin
        in_mem[i]  <= '0;
        out_mem[i] <= '0;
      end
      for (int i = 0; i < NTEMP; i++) tmp_mem[i] <= '0;
    end else begin
      if (in_wr_en) in_mem[in_wr_idx] <= in_wr_data;
      if (out_we)   out_mem[wr_idx[IOW-1:0]] <= wr_data;
      if (tmp_we)   tmp_mem[wr_phys] <= wr_data;
    end
  end

  always_ff @(posedge clk)
    if (const_wr_en) cst_mem[const_wr_idx] <= const_wr_data;

endmodule

// File: rtl/shader_regfile_chk.sv
`timescale 1ns/1ps
module shader_regfile_chk #(
  parameter int W = 128, parameter int NSRC = 3, parameter int NIO = 16,
  parameter int NCONST = 256
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic [1:0]                          thread,
  input logic [NSRC-1:0]                     src_valid,
  input logic [NSRC-1:0][1:0]                src_bank,
  input logic [NSRC-1:0][$clog2(NCONST)-1:0] src_idx,
  input logic [NSRC-1:0][W-1:0]              src_data,
  input logic [NSRC-1:0]                     src_err,
  input logic                                wr_en,
  input logic [1:0]                          wr_bank,
  input logic [$clog2(NCONST)-1:0]           wr_idx,
  input logic [W-1:0]                        wr_data,
  input logic                                wr_err,
  input logic                                in_wr_en,
  input logic [$clog2(NIO)-1:0]              in_wr_idx,
  input logic [W-1:0]                        in_wr_data,
  input logic [$clog2(NIO)-1:0]              out_rd_idx,
  input logic [W-1:0]                        out_rd_data
);
  localparam int IXW = $clog2(NCONST);
  localparam int IOW = $clog2(NIO);

  // R2
  in_fill_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_wr_en |=> (!(src_bank[0] == 2'd0 && src_idx[0] == IXW'($past(in_wr_idx)) && !in_wr_en)
                  || src_data[0] == $past(in_wr_data)));

  // R3
  out_drain_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_err && wr_bank == 2'd1) |=>
      (!(out_rd_idx == $past(wr_idx[IOW-1:0]) && !(wr_en && wr_bank == 2'd1))
       || out_rd_data == $past(wr_data)));

  // R3
  out_read_rejected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid[0] && src_bank[0] == 2'd1) |-> src_err[0]);

  // R5
  err_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_err[0] |-> src_data[0] == '0);

  // R6
  const_write_rejected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_bank == 2'd3) |-> wr_err);

  // R7
  tmp_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_err && wr_bank == 2'd2 && src_bank[0] == 2'd2 && src_idx[0] == wr_idx)
      |-> src_data[0] == wr_data);

  // R8
  err_only_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_err & ~src_valid) == '0);

  // R4
  bad_thread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_bank == 2'd2 && thread == 2'd3) |-> wr_err);
endmodule

bind shader_regfile shader_regfile_chk #(.W(W), .NSRC(NSRC), .NIO(NIO), .NCONST(NCONST)) u_chk (.*);

// File: tb/shader_regfile_tb.sv
`timescale 1ns/1ps
module shader_regfile_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [1:0] thread;
  logic [2:0] src_valid;
  logic [2:0][1:0] src_bank;
  logic [2:0][7:0] src_idx;
  logic [2:0][127:0] src_data;
  logic [2:0] src_err;
  logic wr_en; logic [1:0] wr_bank; logic [7:0] wr_idx; logic [127:0] wr_data; logic wr_err;
  logic in_wr_en; logic [3:0] in_wr_idx; logic [127:0] in_wr_data;
  logic const_wr_en; logic [7:0] const_wr_idx; logic [127:0] const_wr_data;
  logic [3:0] out_rd_idx; logic [127:0] out_rd_data;

  shader_regfile u_dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;
  logic [127:0] m_in [16], m_out [16], m_tmp [32], m_cst [256];

  function automatic logic [127:0] pat(int a, int b);
    return {32'(a), 32'(b), 32'hC0DE_0000 + 32'(a * 7 + b), ~32'(a ^ b)};
  endfunction

  task automatic chk(string tag, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [127:0] ref_rd(int b, int i, int t, output bit bad);
    logic [127:0] v = '0;
    bad = 0;
    if (b == 0) begin
      if (i >= 16) bad = 1;
      else v = (in_wr_en && int'(in_wr_idx) == i) ? in_wr_data : m_in[i];
    end else if (b == 1) bad = 1;
    else if (b == 2) begin
      if (t >= 3 || i >= 10) bad = 1;
      else begin
        v = m_tmp[t * 10 + i];
        if (wr_en && wr_bank == 2'd2 && int'(wr_idx) == i) v = wr_data;
      end
    end else v = (const_wr_en && int'(const_wr_idx) == i) ? const_wr_data : m_cst[i];
    return bad ? '0 : v;
  endfunction

  function automatic bit wr_ok();
    return (wr_bank == 2'd1 && wr_idx < 16) || (wr_bank == 2'd2 && thread < 3 && wr_idx < 10);
  endfunction

  task automatic idle();
    thread = 0; src_valid = '0; src_bank = '0; src_idx = '0;
    wr_en = 0; wr_bank = 0; wr_idx = 0; wr_data = '0;
    in_wr_en = 0; in_wr_idx = 0; in_wr_data = '0;
    const_wr_en = 0; const_wr_idx = 0; const_wr_data = '0; out_rd_idx = 0;
  endtask

  task automatic src(int k, int b, int i);
    src_valid[k] = 1'b1; src_bank[k] = 2'(b); src_idx[k] = 8'(i);
  endtask

  task automatic step(string tag);
    logic [127:0] e; bit bad; logic [127:0] eo;
    #1;
    for (int k = 0; k < 3; k++) begin
      e = ref_rd(int'(src_bank[k]), int'(src_idx[k]), int'(thread), bad);
      chk(tag, $sformatf("src_data[%0d]", k), src_data[k], e);
      chk(tag, $sformatf("src_err[%0d]", k), 128'(src_err[k]), 128'(src_valid[k] && bad));
    end
    chk(tag, "wr_err", 128'(wr_err), 128'(wr_en && !wr_ok()));
    eo = (wr_en && wr_bank == 2'd1 && wr_idx < 16 && wr_idx[3:0] == out_rd_idx) ? wr_data : m_out[out_rd_idx];
    chk(tag, "out_rd_data", out_rd_data, eo);
    @(posedge clk);
    if (in_wr_en) m_in[in_wr_idx] = in_wr_data;
    if (const_wr_en) m_cst[const_wr_idx] = const_wr_data;
    if (wr_en && wr_ok()) begin
      if (wr_bank == 2'd1) m_out[wr_idx[3:0]] = wr_data;
      else m_tmp[int'(thread) * 10 + int'(wr_idx)] = wr_data;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin m_in[i] = '0; m_out[i] = '0; end
    for (int i = 0; i < 32; i++) m_tmp[i] = '0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset contents
    src(0, 0, 3); src(1, 2, 0); thread = 2; src(2, 2, 9); out_rd_idx = 5;
    step("R1");
    // R6: constant loads
    for (int i = 0; i < 256; i++) begin
      idle(); const_wr_en = 1; const_wr_idx = 8'(i); const_wr_data = pat(3, i); step("R6");
    end
    // R2: input fill
    for (int i = 0; i < 16; i++) begin
      idle(); in_wr_en = 1; in_wr_idx = 4'(i); in_wr_data = pat(0, i); step("R2");
    end
    // R8: three independent reads
    idle(); src(0, 0, 1); src(1, 3, 200); src(2, 0, 15); step("R8");
    // R2: program write to input bank rejected
    idle(); wr_en = 1; wr_bank = 0; wr_idx = 4; wr_data = pat(9, 9); step("R2");
    idle(); src(0, 0, 4); step("R2");
    // R3: output writes and drain
    for (int i = 0; i < 16; i++) begin
      idle(); wr_en = 1; wr_bank = 1; wr_idx = 8'(i); wr_data = pat(1, i);
      out_rd_idx = 4'((i + 15) % 16); step("R3");
    end
    idle(); src(0, 1, 2); src(1, 1, 0); src(2, 3, 0); out_rd_idx = 7; step("R3");
    // R4: per-thread windows
    for (int t = 0; t < 3; t++)
      for (int i = 0; i < 10; i++) begin
        idle(); thread = 2'(t); wr_en = 1; wr_bank = 2; wr_idx = 8'(i); wr_data = pat(10 + t, i);
        step("R4");
      end
    for (int t = 0; t < 3; t++)
      for (int i = 0; i < 10; i += 3) begin
        idle(); thread = 2'(t); src(0, 2, i); src(1, 2, 9 - i); src(2, 2, 0); step("R4");
      end
    // R5: out-of-window write, then check neighbour
    idle(); thread = 0; wr_en = 1; wr_bank = 2; wr_idx = 10; wr_data = pat(77, 1); src(0, 2, 10); step("R5");
    idle(); thread = 1; src(0, 2, 0); step("R5");
    idle(); thread = 3; wr_en = 1; wr_bank = 2; wr_idx = 0; wr_data = pat(77, 2); src(0, 2, 1); step("R5");
    idle(); thread = 2; src(0, 2, 9); src(1, 2, 200); step("R5");
    // R6: program write to constant bank rejected
    idle(); wr_en = 1; wr_bank = 3; wr_idx = 50; wr_data = pat(66, 6); step("R6");
    idle(); src(0, 3, 50); src(1, 3, 255); step("R6");
    // R7: write-first bypass on each bank
    idle(); thread = 1; wr_en = 1; wr_bank = 2; wr_idx = 5; wr_data = pat(5, 5);
    src(0, 2, 5); in_wr_en = 1; in_wr_idx = 2; in_wr_data = pat(6, 6); src(1, 0, 2);
    const_wr_en = 1; const_wr_idx = 9; const_wr_data = pat(7, 7); src(2, 3, 9); step("R7");
    idle(); wr_en = 1; wr_bank = 1; wr_idx = 11; wr_data = pat(8, 8); out_rd_idx = 11; step("R7");
    idle(); out_rd_idx = 11; thread = 1; src(0, 2, 5); step("R7");
    // R9: out-of-range input/output indices
    idle(); wr_en = 1; wr_bank = 1; wr_idx = 16; wr_data = pat(4, 4); out_rd_idx = 0; src(0, 0, 16); src(1, 0, 31); step("R9");
    idle(); out_rd_idx = 0; step("R9");
    // R8: random traffic
    for (int n = 0; n < 400; n++) begin
      idle();
      thread = 2'($urandom);
      src_valid = 3'($urandom);
      for (int k = 0; k < 3; k++) begin
        src_bank[k] = 2'($urandom); src_idx[k] = 8'($urandom % 20);
      end
      wr_en = 1'($urandom); wr_bank = 2'($urandom); wr_idx = 8'($urandom % 20);
      wr_data = {$urandom, $urandom, $urandom, $urandom};
      in_wr_en = 1'($urandom); in_wr_idx = 4'($urandom); in_wr_data = {$urandom, $urandom, $urandom, $urandom};
      const_wr_en = 1'($urandom); const_wr_idx = 8'($urandom % 20); const_wr_data = {$urandom, $urandom, $urandom, $urandom};
      out_rd_idx = 4'($urandom);
      step("R8");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule